// File: doc/BRIEF.md
# Digital PLL Loop-Filter Core

This block holds everything a first-order all-digital phase-locked loop needs except the feedback divider. A reference signal and a feedback signal come in from outside. Either an exclusive-OR phase comparator or an edge-triggered set/clear comparator can be selected. The selected comparator gives the count direction for an up/down loop counter. That counter runs on its own counter clock (`k_clk`). The counter's length can be changed while the loop runs, through a 4-bit length code.

Each time the counter wraps it emits a single-cycle pulse. Wrapping upward gives an advance pulse and wrapping downward gives a retard pulse. Both pulses cross into a second clock domain (`id_clk`), where a toggle stage produces the loop output. An advance pulse shortens one half-period of that output and a retard pulse lengthens one. The user divides the output by N and returns it as the feedback signal. A short counter gives a wide, fast-locking loop. A long counter gives a narrow, slow-locking loop.

Top module: `dpll_core`

## Requirements
- R1: While `rst_n` is low, `dir_o`, `carry_o`, `borrow_o` and `id_out` are all 0, whatever the data inputs are.
- R2: With `det_sel`=0 (exclusive-OR comparator), `dir_o` equals `ref_in` XOR `fb_in` after two `k_clk` synchroniser stages. `dir_o`=1 means count up.
- R3: With `det_sel`=1 (edge comparator), a rising edge on `ref_in` alone sets `dir_o` to 1. A rising edge on `fb_in` alone clears it to 0. With no rising edge, or with rising edges on both inputs in the same sampled cycle, `dir_o` keeps its value.
- R4: For length codes 1 to 15 the counter has code+2 stages and counts modulo 2^(code+2). Counting up from 0, each enabled `k_clk` cycle adds one. Every step from the top value to 0 raises `carry_o` for exactly one `k_clk` cycle.
- R5: When counting down, each step from 0 to the top value raises `borrow_o` for exactly one `k_clk` cycle. Starting from the reset value 0, the first down step already produces a borrow. `carry_o` and `borrow_o` are never high together.
- R6: Length code 0 disables the counter. The count holds its value and neither `carry_o` nor `borrow_o` is raised.
- R7: The length code may change at any `k_clk` edge without a reset. The first step after a change works on the held count reduced modulo the new length. Example: counting up 40 steps at code 4, then 20 steps at code 1, gives exactly 2 carries.
- R8: With no pending pulses, `id_out` toggles every `ID_HALF` `id_clk` cycles (default 2).
- R9: Each carry makes one later half-period of `id_out` one `id_clk` cycle shorter. Each borrow makes one later half-period one `id_clk` cycle longer.
- R10: In a closed loop with `id_out` divided by 8 as the feedback, the loop locks for codes 1 and 2, for both comparators, and for references both slower and faster than nominal. Once settled, the feedback and reference rising-edge counts differ by at most 1, and the reference-to-feedback lag varies by at most 8 `k_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk | input | 1 | Loop counter clock |
| id_clk | input | 1 | Output stage clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ref_in | input | 1 | Reference signal (asynchronous) |
| fb_in | input | 1 | Feedback signal from the external divider (asynchronous) |
| len_code | input | 4 | Counter length code: 0 = disabled, n = n+2 stages |
| det_sel | input | 1 | 0 = exclusive-OR comparator, 1 = edge comparator |
| dir_o | output | 1 | Count direction from the selected comparator (1 = up) |
| carry_o | output | 1 | One-cycle pulse on an upward wrap |
| borrow_o | output | 1 | One-cycle pulse on a downward wrap |
| id_out | output | 1 | Loop output |

## Verification
The bench goes after the wrap boundaries of the counter. A design that handled the top or bottom value wrongly would give one pulse too many or too few over an exact step count. It would also miss the borrow on the very first down step from zero. The length-change case catches a counter that keeps stale high bits: such a counter would run on to the old modulus and give no carries in the short window. The edge comparator is driven with rising edges on both inputs in the same cycle, which catches a set-dominant or clear-dominant latch. Closed-loop runs with both comparators catch a sign error in the half-period adjustment, because such a loop drifts instead of holding a steady lag.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic {
    DET_XOR  = 1'b0,
    DET_EDGE = 1'b1
  } det_sel_e;

endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
  import dpll_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic     k_clk,
  input  logic     rst_n,
  input  logic     ref_in,
  input  logic     fb_in,
  input  det_sel_e sel,
  output logic     dir_up
);

  logic [SYNC_N-1:0] ref_s, fb_s;
  logic ref_prev, fb_prev;
  logic ref_sync, fb_sync;
  logic ref_rise, fb_rise;
  logic xor_pd, edge_q;

  // bring both asynchronous inputs into the counter clock domain
  always_ff @(posedge k_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s    <= '0;
      fb_s     <= '0;
      ref_prev <= 1'b0;
      fb_prev  <= 1'b0;
    end else begin
      ref_s    <= {ref_s[SYNC_N-2:0], ref_in};
      fb_s     <= {fb_s[SYNC_N-2:0], fb_in};
      ref_prev <= ref_sync;
      fb_prev  <= fb_sync;
    end
  end

  assign ref_sync = ref_s[SYNC_N-1];
  assign fb_sync  = fb_s[SYNC_N-1];
  assign ref_rise = ref_sync & ~ref_prev;
  assign fb_rise  = fb_sync & ~fb_prev;
  assign xor_pd   = ref_sync ^ fb_sync;

  // set/clear latch: reference edge sets, feedback edge clears, a tie holds
  always_ff @(posedge k_clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
    end else if (ref_rise && !fb_rise) begin
      edge_q <= 1'b1;
    end else if (fb_rise && !ref_rise) begin
      edge_q <= 1'b0;
    end
  end

  assign dir_up = (sel == DET_XOR) ? xor_pd : edge_q;

  AST_EDGE_SET: assert property (@(posedge k_clk) disable iff (!rst_n)
    (ref_rise && !fb_rise) |=> edge_q); // R3
  AST_EDGE_CLEAR: assert property (@(posedge k_clk) disable iff (!rst_n)
    (fb_rise && !ref_rise) |=> !edge_q); // R3
  AST_EDGE_HOLD: assert property (@(posedge k_clk) disable iff (!rst_n)
    (ref_rise == fb_rise) |=> $stable(edge_q)); // R3

endmodule

// File: rtl/dpll_kcounter.sv
module dpll_kcounter #(
  parameter int CODE_W = 4
) (
  input  logic              k_clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] len_code,
  input  logic              dir_up,
  output logic              carry_o,
  output logic              borrow_o,
  output logic              carry_tgl_o,
  output logic              borrow_tgl_o
);

  localparam int CNT_W = (1 << CODE_W) + 1;

  // width mask for a given code: code+2 low ones, none when disabled
  function automatic logic [CNT_W-1:0] len_mask(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(code) + 2) m[i] = 1'b1;
    end
    return (code == '0) ? '0 : m;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_eff, cnt_nxt, mask;
  logic en, at_top, at_bot, wrap_up, wrap_dn;
  logic carry_q, borrow_q, ctgl_q, btgl_q;

  always_comb begin
    mask    = len_mask(len_code);
    en      = |len_code;
    cnt_eff = cnt_q & mask;
    at_top  = (cnt_eff == mask);
    at_bot  = (cnt_eff == '0);
    if (dir_up) cnt_nxt = at_top ? '0 : cnt_eff + 1'b1;
    else        cnt_nxt = at_bot ? mask : cnt_eff - 1'b1;
  end

  assign wrap_up = en & dir_up & at_top;
  assign wrap_dn = en & ~dir_up & at_bot;

  always_ff @(posedge k_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
      ctgl_q   <= 1'b0;
      btgl_q   <= 1'b0;
    end else begin
      carry_q  <= wrap_up;
      borrow_q <= wrap_dn;
      if (en)      cnt_q  <= cnt_nxt;
      if (wrap_up) ctgl_q <= ~ctgl_q;
      if (wrap_dn) btgl_q <= ~btgl_q;
    end
  end

  assign carry_o      = carry_q;
  assign borrow_o     = borrow_q;
  assign carry_tgl_o  = ctgl_q;
  assign borrow_tgl_o = btgl_q;

  AST_CARRY_SINGLE: assert property (@(posedge k_clk) disable iff (!rst_n)
    carry_q |=> !carry_q); // R4
  AST_BORROW_SINGLE: assert property (@(posedge k_clk) disable iff (!rst_n)
    borrow_q |=> !borrow_q); // R5
  AST_NO_DUAL_PULSE: assert property (@(posedge k_clk) disable iff (!rst_n)
    !(carry_q && borrow_q)); // R5
  AST_DISABLED_QUIET: assert property (@(posedge k_clk) disable iff (!rst_n)
    !en |=> (!carry_q && !borrow_q)); // R6
  AST_DISABLED_HOLD: assert property (@(posedge k_clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q)); // R6
  AST_CNT_FITS: assert property (@(posedge k_clk) disable iff (!rst_n)
    en |=> ((cnt_q & ~$past(mask)) == '0)); // R7

endmodule

// File: rtl/dpll_id_stage.sv
module dpll_id_stage #(
  parameter int ID_HALF = 2,
  parameter int SYNC_N  = 2
) (
  input  logic id_clk,
  input  logic rst_n,
  input  logic carry_tgl,
  input  logic borrow_tgl,
  output logic id_out
);

  localparam int HW = $clog2(ID_HALF + 2);

  // length of the next half-period given the requests waiting for it
  function automatic logic [HW-1:0] half_after(input logic ins, input logic del);
    if (ins && !del) return HW'(ID_HALF - 1);
    if (del && !ins) return HW'(ID_HALF + 1);
    return HW'(ID_HALF);
  endfunction

  logic [SYNC_N:0] c_s, b_s;
  logic new_ins, new_del, ins_pend, del_pend, ins_all, del_all;
  logic [HW-1:0] tick_q, lim_q;
  logic half_end, out_q;

  always_ff @(posedge id_clk or negedge rst_n) begin
    if (!rst_n) begin
      c_s <= '0;
      b_s <= '0;
    end else begin
      c_s <= {c_s[SYNC_N-1:0], carry_tgl};
      b_s <= {b_s[SYNC_N-1:0], borrow_tgl};
    end
  end

  assign new_ins  = c_s[SYNC_N] ^ c_s[SYNC_N-1];
  assign new_del  = b_s[SYNC_N] ^ b_s[SYNC_N-1];
  assign ins_all  = ins_pend | new_ins;
  assign del_all  = del_pend | new_del;
  assign half_end = (tick_q == lim_q - HW'(1));

  always_ff @(posedge id_clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      lim_q    <= HW'(ID_HALF);
      out_q    <= 1'b0;
      ins_pend <= 1'b0;
      del_pend <= 1'b0;
    end else if (half_end) begin
      out_q    <= ~out_q;
      tick_q   <= '0;
      lim_q    <= half_after(ins_all, del_all);
      ins_pend <= 1'b0;
      del_pend <= 1'b0;
    end else begin
      tick_q   <= tick_q + HW'(1);
      ins_pend <= ins_all;
      del_pend <= del_all;
    end
  end

  assign id_out = out_q;

  AST_HALF_BOUND: assert property (@(posedge id_clk) disable iff (!rst_n)
    (lim_q >= HW'(ID_HALF - 1)) && (lim_q <= HW'(ID_HALF + 1))); // R9
  AST_TICK_BELOW_LIMIT: assert property (@(posedge id_clk) disable iff (!rst_n)
    tick_q < lim_q); // R8
  AST_OUT_STEADY: assert property (@(posedge id_clk) disable iff (!rst_n)
    !half_end |=> $stable(out_q)); // R8

endmodule

// File: rtl/dpll_core.sv
module dpll_core
  import dpll_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int SYNC_N  = 2,
  parameter int ID_HALF = 2
) (
  input  logic              k_clk,
  input  logic              id_clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              fb_in,
  input  logic [CODE_W-1:0] len_code,
  input  logic              det_sel,
  output logic              dir_o,
  output logic              carry_o,
  output logic              borrow_o,
  output logic              id_out
);

  logic dir_up, carry_tgl, borrow_tgl;

  dpll_phase_det #(.SYNC_N(SYNC_N)) u_pd (
    .k_clk  (k_clk),
    .rst_n  (rst_n),
    .ref_in (ref_in),
    .fb_in  (fb_in),
    .sel    (det_sel_e'(det_sel)),
    .dir_up (dir_up)
  );

  dpll_kcounter #(.CODE_W(CODE_W)) u_kcnt (
    .k_clk        (k_clk),
    .rst_n        (rst_n),
    .len_code     (len_code),
    .dir_up       (dir_up),
    .carry_o      (carry_o),
    .borrow_o     (borrow_o),
    .carry_tgl_o  (carry_tgl),
    .borrow_tgl_o (borrow_tgl)
  );

  dpll_id_stage #(.ID_HALF(ID_HALF), .SYNC_N(SYNC_N)) u_ids (
    .id_clk     (id_clk),
    .rst_n      (rst_n),
    .carry_tgl  (carry_tgl),
    .borrow_tgl (borrow_tgl),
    .id_out     (id_out)
  );

  assign dir_o = dir_up;

endmodule

// File: tb/test_dpll_core.sv
`timescale 1ns/1ps
module test_dpll_core;

  localparam int WD_LIMIT = 150000;
  localparam int NV = 8;
  // code, up(1)/down(0), enabled steps
  localparam int VEC [NV][3] = '{
    '{1, 1, 40}, '{1, 0, 40}, '{2, 1, 70}, '{4, 0, 100},
    '{15, 1, 200}, '{0, 1, 100}, '{0, 0, 100}, '{3, 0, 33}
  };

  logic k_clk = 1'b0, id_clk = 1'b0, rst_n = 1'b0;
  logic ref_man = 1'b0, fb_man = 1'b0, ref_gen = 1'b0, fb_div = 1'b0;
  logic loop_on = 1'b0;
  logic [3:0] len_code = 4'd0;
  logic det_sel = 1'b0;
  logic ref_in, fb_in, dir_o, carry_o, borrow_o, id_out;
  int ref_half = 165;
  int n_chk = 0, n_bad = 0, wd = 0;
  bit done = 1'b0;

  assign ref_in = loop_on ? ref_gen : ref_man;
  assign fb_in  = loop_on ? fb_div : fb_man;

  dpll_core i_dpll_core (
    .k_clk(k_clk), .id_clk(id_clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .len_code(len_code), .det_sel(det_sel), .dir_o(dir_o), .carry_o(carry_o),
    .borrow_o(borrow_o), .id_out(id_out)
  );

  always #5 k_clk = ~k_clk;
  initial begin #2; forever #5 id_clk = ~id_clk; end

  // external divide-by-8 feedback
  int div_cnt = 0;
  always @(posedge id_out or negedge rst_n) begin
    if (!rst_n) begin div_cnt <= 0; fb_div <= 1'b0; end
    else if (div_cnt == 3) begin div_cnt <= 0; fb_div <= ~fb_div; end
    else div_cnt <= div_cnt + 1;
  end

  always begin
    if (loop_on) begin ref_gen = 1'b1; #(ref_half); ref_gen = 1'b0; #(ref_half); end
    else begin ref_gen = 1'b0; @(loop_on); end
  end

  // counter-domain monitor: pulses, lag statistics
  int tick = 0, last_ref_t = 0, lag = 0, lag_min = 0, lag_max = 0, n_ref = 0, n_fb = 0;
  int car_cnt = 0, bor_cnt = 0, car_double = 0;
  bit collect = 1'b0, collect_d = 1'b0;
  logic ref_d = 1'b0, fb_d = 1'b0, car_d = 1'b0;
  always @(negedge k_clk) begin
    tick++;
    if (collect && !collect_d) begin n_ref = 0; n_fb = 0; lag_min = 1 << 30; lag_max = -1; end
    collect_d = collect;
    if (ref_in && !ref_d) begin last_ref_t = tick; if (collect) n_ref++; end
    if (fb_in && !fb_d && collect) begin
      lag = tick - last_ref_t; n_fb++;
      if (lag < lag_min) lag_min = lag;
      if (lag > lag_max) lag_max = lag;
    end
    ref_d = ref_in; fb_d = fb_in;
    if (carry_o) car_cnt++;
    if (borrow_o) bor_cnt++;
    if (carry_o && car_d) car_double++;
    car_d = carry_o;
  end

  // output-domain monitor: half-period length histogram
  int run = 0, n_short = 0, n_norm = 0, n_long = 0;
  bit first_run = 1'b1;
  logic out_d = 1'b0;
  always @(negedge id_clk) begin
    if (!rst_n) begin run = 0; first_run = 1'b1; out_d = 1'b0; end
    else begin
      run++;
      if (id_out != out_d) begin
        if (!first_run) begin
          if (run < 2) n_short++; else if (run == 2) n_norm++; else n_long++;
        end
        first_run = 1'b0; run = 0; out_d = id_out;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge k_clk) begin
    wd++;
    if (wd >= WD_LIMIT && !done) begin
      done = 1'b1; n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", wd, WD_LIMIT);
      summary(); $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int code, input int m);
    int p;
    if (code == 0) return 0;
    p = 1 << (code + 2);
    return m / p;
  endfunction

  function automatic int exp_borrows(input int code, input int m);
    int p;
    if (code == 0 || m == 0) return 0;
    p = 1 << (code + 2);
    return (m - 1) / p + 1;
  endfunction

  task automatic prep(input bit up);
    rst_n = 1'b0; loop_on = 1'b0; len_code = 4'd0; det_sel = 1'b0;
    ref_man = up; fb_man = 1'b0;
    repeat (3) @(negedge k_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge k_clk);
  endtask

  task automatic steps(input int code, input int m);
    len_code = 4'(code);
    repeat (m) @(negedge k_clk);
    len_code = 4'd0;
    @(negedge k_clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge k_clk);
  endtask

  task automatic lock_case(input string tag, input int code, input bit sel, input int half);
    rst_n = 1'b0; loop_on = 1'b0; len_code = 4'(code); det_sel = sel; ref_half = half;
    ref_man = 1'b0; fb_man = 1'b0;
    repeat (3) @(negedge k_clk);
    rst_n = 1'b1; loop_on = 1'b1;
    #(60 * 2 * half);
    collect = 1'b1;
    #(30 * 2 * half);
    collect = 1'b0;
    @(negedge k_clk);
    chk({tag, " edge-count match"}, ((n_ref - n_fb) <= 1 && (n_fb - n_ref) <= 1) ? 1 : 0, 1);
    chk({tag, " lag spread<=8"}, (lag_max >= 0 && (lag_max - lag_min) <= 8) ? 1 : 0, 1);
    loop_on = 1'b0;
  endtask

  initial begin
    int c0, b0, s0, l0, nn0;
    // R1: reset state with active inputs
    rst_n = 1'b0; ref_man = 1'b1; len_code = 4'd1;
    repeat (3) @(negedge k_clk);
    chk("R1 dir", int'(dir_o), 0);
    chk("R1 carry", int'(carry_o), 0);
    chk("R1 borrow", int'(borrow_o), 0);
    chk("R1 out", int'(id_out), 0);

    // R2: exclusive-OR comparator
    prep(1'b0);
    ref_man = 1'b1; fb_man = 1'b0; settle(); chk("R2 10", int'(dir_o), 1);
    fb_man = 1'b1; settle(); chk("R2 11", int'(dir_o), 0);
    ref_man = 1'b0; settle(); chk("R2 01", int'(dir_o), 1);

    // R3: edge comparator
    prep(1'b0); det_sel = 1'b1; settle();
    chk("R3 idle", int'(dir_o), 0);
    ref_man = 1'b1; settle(); chk("R3 ref edge sets", int'(dir_o), 1);
    ref_man = 1'b0; settle(); chk("R3 ref fall holds", int'(dir_o), 1);
    fb_man = 1'b1; settle(); chk("R3 fb edge clears", int'(dir_o), 0);
    fb_man = 1'b0; settle();
    ref_man = 1'b1; fb_man = 1'b1; settle(); chk("R3 tie holds 0", int'(dir_o), 0);
    ref_man = 1'b0; fb_man = 1'b0; settle();
    ref_man = 1'b1; settle(); ref_man = 1'b0; settle();
    ref_man = 1'b1; fb_man = 1'b1; settle(); chk("R3 tie holds 1", int'(dir_o), 1);

    // R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      int code, up, m, ec, eb;
      string tag;
      code = VEC[v][0]; up = VEC[v][1]; m = VEC[v][2];
      tag = (code == 0) ? "R6" : (up != 0 ? "R4" : "R5");
      prep(up != 0);
      c0 = car_cnt; b0 = bor_cnt;
      steps(code, m);
      ec = (up != 0) ? exp_pulses(code, m) : 0;
      eb = (up != 0) ? 0 : exp_borrows(code, m);
      chk({tag, " carries"}, car_cnt - c0, ec);
      chk({tag, " borrows"}, bor_cnt - b0, eb);
    end
    chk("R4 carry width one cycle", car_double, 0);

    // R7: run-time length change
    prep(1'b1);
    c0 = car_cnt;
    len_code = 4'd4; repeat (40) @(negedge k_clk);
    chk("R7 none at long length", car_cnt - c0, 0);
    c0 = car_cnt;
    len_code = 4'd1; repeat (20) @(negedge k_clk);
    len_code = 4'd0; @(negedge k_clk);
    chk("R7 carries after shortening", car_cnt - c0, 2);

    // R8: idle output cadence
    prep(1'b0);
    s0 = n_short; l0 = n_long; nn0 = n_norm;
    #600;
    chk("R8 no short halves", n_short - s0, 0);
    chk("R8 no long halves", n_long - l0, 0);
    chk("R8 regular halves", (n_norm - nn0 >= 25) ? 1 : 0, 1);

    // R9: single carry shortens, single borrow lengthens
    prep(1'b1);
    s0 = n_short; l0 = n_long; c0 = car_cnt;
    steps(1, 8);
    #400;
    chk("R9 one carry", car_cnt - c0, 1);
    chk("R9 short half", n_short - s0, 1);
    chk("R9 no long half", n_long - l0, 0);
    prep(1'b0);
    s0 = n_short; l0 = n_long; b0 = bor_cnt;
    steps(1, 1);
    #400;
    chk("R9 one borrow", bor_cnt - b0, 1);
    chk("R9 long half", n_long - l0, 1);
    chk("R9 no short half", n_short - s0, 0);

    // R10: closed-loop lock
    lock_case("R10 edge code1 slow ref", 1, 1'b1, 165);
    lock_case("R10 edge code1 fast ref", 1, 1'b1, 156);
    lock_case("R10 edge code2 slow ref", 2, 1'b1, 165);
    lock_case("R10 xor code1 slow ref", 1, 1'b0, 165);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule